// File: doc/BRIEF.md
# Programmable-Trigger Interrupt Aggregator

This block collects a vector of external interrupt lines and merges them into a single request toward a parent interrupt controller. Software programs each source separately for edge or level sensing and for its active sense. Every input passes through a two-flop synchronizer. Edge events are held in a sticky pending bit until software acknowledges them by writing ones. Level sources report their live, qualified level. Software can also inject an event on any source through a force register.

A per-source enable mask decides which pending sources count toward the merged request. The merged output has a programmable signalling style: a level that stays asserted while anything is pending, or a single-cycle pulse for each newly pending source. It also has a programmable active sense. All control goes through a plain synchronous register port with word address, write data, write strobe and combinational read data.

Top module: `trig_irq_ctrl`

## Requirements
- R1: After reset the enable, output-style and output-sense registers read 0. The source-style and source-sense registers read all ones, so every source starts as rising-edge. Status reads 0 and `irqOut` is 0.
- R2: The registers sit at byte offsets 0x00 enable, 0x04 status, 0x08 source style, 0x0C source sense, 0x10 output style and 0x14 output sense. The output registers keep bit 0 only and read 0 above it. Any other address, including a misaligned one, reads 0 and ignores writes.
- R3: A source with style bit 1 is edge sensed. Sense bit 1 selects rising and sense bit 0 selects falling. The selected edge sets the status bit, which then stays set until acknowledged, even after the input returns.
- R4: A source with style bit 0 is level sensed. Sense bit 1 means active-high and sense bit 0 means active-low. Its status bit follows the qualified level. Writing 1 to it has no lasting effect while the level is still active.
- R5: Writing 1 to a bit of the status register at 0x04 clears that latched event, and writing 0 leaves it alone. Writing all ones clears every latched event. An edge arriving in the same cycle as the acknowledge wins.
- R6: Writing 1 to bit i at offset 0x18 sets status bit i as if an edge had occurred. That offset always reads 0.
- R7: A pending source affects `irqOut` only while its enable bit (offset 0x00) is 1.
- R8: With output style 0, the internal request is asserted one cycle after any enabled status bit is set. It stays asserted while any enabled status bit remains set.
- R9: With output style 1, the internal request is a one-cycle pulse, one cycle after an enabled status bit goes from 0 to 1, for each such new event.
- R10: Output sense 0 drives `irqOut` active-high, and sense 1 drives it active-low. A sense change takes effect right after the write.
- R11: A level change on an input shows in status after 2 clock edges. An edge event shows in status after 3 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, sampled on the rising clock edge |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| irqIn | input | 32 | Raw asynchronous interrupt sources |
| irqOut | output | 1 | Merged request toward the parent controller |

## Verification
On every cycle, the assertions check four things. A latched edge event never disappears without an acknowledge. The force offset and unmapped offsets read zero. A cleared enable mask keeps the output at its inactive sense. The output request matches the enabled status one cycle earlier, as a level or as a new-event pulse. The bench scenarios are what show the per-source trigger decoding, sweeping every source through all four style/sense codes. They also show the exact synchronizer latency, the ineffective acknowledge of an active level, the behaviour of zero bits in an acknowledge, and register readback.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;

  // Word index of each register (byte offset / 4).
  localparam int IDX_ENABLE = 0;
  localparam int IDX_STATUS = 1;
  localparam int IDX_SMODE  = 2;
  localparam int IDX_SPOL   = 3;
  localparam int IDX_OMODE  = 4;
  localparam int IDX_OPOL   = 5;
  localparam int IDX_FORCE  = 6;

  typedef enum logic [2:0] {
    RS_ENABLE = 3'd0,
    RS_STATUS = 3'd1,
    RS_SMODE  = 3'd2,
    RS_SPOL   = 3'd3,
    RS_OMODE  = 3'd4,
    RS_OPOL   = 3'd5,
    RS_FORCE  = 3'd6,
    RS_NONE   = 3'd7
  } regSel_t;

  // Strobes from control to datapath; the data bits travel on the write bus.
  typedef struct packed {
    logic ackStb;
    logic forceStb;
  } dpStrobe_t;

endpackage

// File: rtl/trig_irq_ctl.sv
module trig_irq_ctl
  import trig_irq_pkg::*;
#(
  parameter int SRC_N  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SRC_N-1:0]  busWdata,
  input  logic              busWe,
  input  logic [SRC_N-1:0]  statusVec,
  output logic [SRC_N-1:0]  busRdata,
  output dpStrobe_t         stb,
  output logic [SRC_N-1:0]  enableVec,
  output logic [SRC_N-1:0]  srcModeVec,
  output logic [SRC_N-1:0]  srcPolVec,
  output logic              outMode,
  output logic              outPol
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  regSel_t           sel;

  assign wordIdx = busAddr[ADDR_W-1:2];

  // Address decode: aligned accesses to the seven mapped words only.
  always_comb begin
    sel = RS_NONE;
    if (busAddr[1:0] == 2'b00) begin
      case (wordIdx)
        WORD_W'(IDX_ENABLE): sel = RS_ENABLE;
        WORD_W'(IDX_STATUS): sel = RS_STATUS;
        WORD_W'(IDX_SMODE):  sel = RS_SMODE;
        WORD_W'(IDX_SPOL):   sel = RS_SPOL;
        WORD_W'(IDX_OMODE):  sel = RS_OMODE;
        WORD_W'(IDX_OPOL):   sel = RS_OPOL;
        WORD_W'(IDX_FORCE):  sel = RS_FORCE;
        default:             sel = RS_NONE;
      endcase
    end
  end

  // Configuration registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableVec  <= '0;
      srcModeVec <= '1;
      srcPolVec  <= '1;
      outMode    <= 1'b0;
      outPol     <= 1'b0;
    end else if (busWe) begin
      case (sel)
        RS_ENABLE: enableVec  <= busWdata;
        RS_SMODE:  srcModeVec <= busWdata;
        RS_SPOL:   srcPolVec  <= busWdata;
        RS_OMODE:  outMode    <= busWdata[0];
        RS_OPOL:   outPol     <= busWdata[0];
        default: ;
      endcase
    end
  end

  // Strobes for the write-one registers held in the datapath.
  always_comb begin
    stb          = '0;
    stb.ackStb   = busWe && (sel == RS_STATUS);
    stb.forceStb = busWe && (sel == RS_FORCE);
  end

  // Read multiplexer.
  always_comb begin
    case (sel)
      RS_ENABLE: busRdata = enableVec;
      RS_STATUS: busRdata = statusVec;
      RS_SMODE:  busRdata = srcModeVec;
      RS_SPOL:   busRdata = srcPolVec;
      RS_OMODE:  busRdata = SRC_N'(outMode);
      RS_OPOL:   busRdata = SRC_N'(outPol);
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/trig_irq_dp.sv
module trig_irq_dp
  import trig_irq_pkg::*;
#(
  parameter int SRC_N       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] irqIn,
  input  dpStrobe_t        stb,
  input  logic [SRC_N-1:0] wdata,
  input  logic [SRC_N-1:0] srcModeVec,
  input  logic [SRC_N-1:0] srcPolVec,
  input  logic [SRC_N-1:0] enableVec,
  input  logic             outMode,
  input  logic             outPol,
  output logic [SRC_N-1:0] statusVec,
  output logic             irqOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SRC_N-1:0] pendVec;
  logic [SRC_N-1:0] pendPrev;
  logic             anyPend;
  logic             newEvt;
  logic             activeReg;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevBit;
    logic                   syncBit;
    logic                   riseHit;
    logic                   fallHit;
    logic                   edgeHit;
    logic                   levelHit;
    logic                   setBit;
    logic                   clrBit;
    logic                   latchBit;

    // Synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain   <= '0;
        prevBit <= 1'b0;
      end else begin
        chain   <= {chain[LAST-1:0], irqIn[i]};
        prevBit <= chain[LAST];
      end
    end

    assign syncBit  = chain[LAST];
    assign riseHit  = syncBit & ~prevBit;
    assign fallHit  = ~syncBit & prevBit;
    assign edgeHit  = srcModeVec[i] & (srcPolVec[i] ? riseHit : fallHit);
    assign levelHit = ~srcModeVec[i] & (syncBit == srcPolVec[i]);
    assign setBit   = edgeHit | (stb.forceStb & wdata[i]);
    assign clrBit   = stb.ackStb & wdata[i];

    // Sticky event latch; a new event beats a same-cycle acknowledge.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latchBit <= 1'b0;
      end else if (setBit) begin
        latchBit <= 1'b1;
      end else if (clrBit) begin
        latchBit <= 1'b0;
      end
    end

    assign statusVec[i] = latchBit | levelHit;
  end

  assign pendVec = statusVec & enableVec;
  assign anyPend = |pendVec;
  assign newEvt  = |(pendVec & ~pendPrev);

  // Output stage: level or per-event pulse, then the programmable sense.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPrev  <= '0;
      activeReg <= 1'b0;
    end else begin
      pendPrev  <= pendVec;
      activeReg <= outMode ? newEvt : anyPend;
    end
  end

  assign irqOut = activeReg ^ outPol;

endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl
  import trig_irq_pkg::*;
#(
  parameter int SRC_N       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SRC_N-1:0]  busWdata,
  input  logic              busWe,
  output logic [SRC_N-1:0]  busRdata,
  input  logic [SRC_N-1:0]  irqIn,
  output logic              irqOut
);

  dpStrobe_t        stb;
  logic [SRC_N-1:0] statusVec;
  logic [SRC_N-1:0] enableVec;
  logic [SRC_N-1:0] srcModeVec;
  logic [SRC_N-1:0] srcPolVec;
  logic             outMode;
  logic             outPol;

  trig_irq_ctl #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busWe      (busWe),
    .statusVec  (statusVec),
    .busRdata   (busRdata),
    .stb        (stb),
    .enableVec  (enableVec),
    .srcModeVec (srcModeVec),
    .srcPolVec  (srcPolVec),
    .outMode    (outMode),
    .outPol     (outPol)
  );

  trig_irq_dp #(.SRC_N(SRC_N), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .irqIn      (irqIn),
    .stb        (stb),
    .wdata      (busWdata),
    .srcModeVec (srcModeVec),
    .srcPolVec  (srcPolVec),
    .enableVec  (enableVec),
    .outMode    (outMode),
    .outPol     (outPol),
    .statusVec  (statusVec),
    .irqOut     (irqOut)
  );

endmodule

// File: rtl/trig_irq_ctrl_chk.sv
module trig_irq_ctrl_chk #(
  parameter int SRC_N  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [SRC_N-1:0]  busWdata,
  input logic              busWe,
  input logic [SRC_N-1:0]  busRdata,
  input logic              irqOut,
  input logic [SRC_N-1:0]  statusVec,
  input logic [SRC_N-1:0]  enableVec,
  input logic [SRC_N-1:0]  srcModeVec,
  input logic              outMode,
  input logic              outPol
);

  logic [1:0]       sinceRst;
  logic [SRC_N-1:0] ackMask;
  logic [SRC_N-1:0] pendVec;
  logic             warm;
  logic             mappedAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assign warm       = (sinceRst == 2'd3);
  assign ackMask    = (busWe && busAddr == ADDR_W'(8'h04)) ? busWdata : '0;
  assign pendVec    = statusVec & enableVec;
  assign mappedAddr = (busAddr[1:0] == 2'b00) && (busAddr[ADDR_W-1:2] < (ADDR_W-2)'(7));

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    warm |=> ((($past(statusVec) & $past(srcModeVec) & ~$past(ackMask) & srcModeVec) & ~statusVec) == '0)); // R3

  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(8'h18)) |-> (busRdata == '0)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mappedAddr |-> (busRdata == '0)); // R2

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enableVec == '0) |=> (irqOut == outPol)); // R7

  AST_LEVEL_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !outMode) |=> ((irqOut ^ outPol) == (|$past(pendVec)))); // R8

  AST_PULSE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outMode) |=> ((irqOut ^ outPol) == (|($past(pendVec) & ~$past(pendVec, 2))))); // R9

endmodule

bind trig_irq_ctrl trig_irq_ctrl_chk #(.SRC_N(SRC_N), .ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busWe      (busWe),
  .busRdata   (busRdata),
  .irqOut     (irqOut),
  .statusVec  (statusVec),
  .enableVec  (enableVec),
  .srcModeVec (srcModeVec),
  .outMode    (outMode),
  .outPol     (outPol)
);

// File: tb/sim_trig_irq_ctrl.sv
module sim_trig_irq_ctrl;

  localparam logic [7:0] A_EN = 8'h00, A_ST = 8'h04, A_SM = 8'h08, A_SP = 8'h0C,
                         A_OM = 8'h10, A_OP = 8'h14, A_FO = 8'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic [31:0] irqIn = '0;
  logic        irqOut;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trig_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .irqIn(irqIn), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    waitEdges(2);

    // Reset state
    checkReg("R1 enable", A_EN, 32'h0);
    checkReg("R1 status", A_ST, 32'h0);
    checkReg("R1 srcMode", A_SM, 32'hFFFF_FFFF);
    checkReg("R1 srcPol", A_SP, 32'hFFFF_FFFF);
    checkReg("R1 outMode", A_OM, 32'h0);
    checkReg("R1 outPol", A_OP, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // Register map, readback, unmapped and misaligned accesses
    busWrite(A_EN, 32'hA5A5_0F0F);
    checkReg("R2 enable rb", A_EN, 32'hA5A5_0F0F);
    busWrite(A_SM, 32'h1234_5678);
    checkReg("R2 srcMode rb", A_SM, 32'h1234_5678);
    busWrite(A_SP, 32'h8765_4321);
    checkReg("R2 srcPol rb", A_SP, 32'h8765_4321);
    busWrite(A_OM, 32'hFFFF_FFFE);
    checkReg("R2 outMode bit0 only", A_OM, 32'h0);
    busWrite(A_OP, 32'hFFFF_FFFE);
    checkReg("R2 outPol bit0 only", A_OP, 32'h0);
    checkReg("R2 force reads 0", A_FO, 32'h0);
    busWrite(8'h1C, 32'hFFFF_FFFF);
    checkReg("R2 unmapped 0x1C", 8'h1C, 32'h0);
    busWrite(8'h01, 32'h0);
    checkReg("R2 misaligned write ignored", A_EN, 32'hA5A5_0F0F);
    checkReg("R2 misaligned read", 8'h01, 32'h0);
    busWrite(8'h40, 32'h0);
    checkReg("R2 far write ignored", A_EN, 32'hA5A5_0F0F);
    busWrite(A_EN, 32'h0);
    busWrite(A_SM, 32'hFFFF_FFFF);
    busWrite(A_SP, 32'hFFFF_FFFF);
    waitEdges(3);
    busWrite(A_ST, 32'hFFFF_FFFF);
    checkReg("R5 all-ones ack", A_ST, 32'h0);

    // Sweep every source through all four trigger codes
    for (int i = 0; i < 32; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic modeBit, polBit, idle;
        logic [31:0] bitI;
        modeBit = m[1];
        polBit  = m[0];
        idle    = ~polBit;
        bitI    = 32'h1 << i;
        busWrite(A_SM, modeBit ? 32'hFFFF_FFFF : ~bitI);
        busWrite(A_SP, polBit ? 32'hFFFF_FFFF : ~bitI);
        irqIn[i] = idle;
        waitEdges(4);
        busWrite(A_ST, 32'hFFFF_FFFF);
        checkReg("R5 idle after ack", A_ST, 32'h0);
        irqIn[i] = ~idle;
        waitEdges(2);
        checkReg("R11 two edges", A_ST, modeBit ? 32'h0 : bitI);
        waitEdges(1);
        checkReg(modeBit ? "R3 edge latched" : "R4 level seen", A_ST, bitI);
        if (modeBit) begin
          irqIn[i] = idle;
          waitEdges(3);
          checkReg("R3 sticky after return", A_ST, bitI);
          busWrite(A_ST, ~bitI);
          checkReg("R5 zero bit keeps", A_ST, bitI);
          busWrite(A_ST, bitI);
          checkReg("R5 one bit clears", A_ST, 32'h0);
        end else begin
          busWrite(A_ST, bitI);
          checkReg("R4 ack while active", A_ST, bitI);
          irqIn[i] = idle;
          waitEdges(3);
          checkReg("R4 level released", A_ST, 32'h0);
        end
      end
      irqIn[i] = 1'b0;
    end

    // Output stage
    busWrite(A_SM, 32'hFFFF_FFFF);
    busWrite(A_SP, 32'hFFFF_FFFF);
    waitEdges(3);
    busWrite(A_ST, 32'hFFFF_FFFF);
    busWrite(A_FO, 32'h20);
    checkReg("R6 force sets status", A_ST, 32'h20);
    checkReg("R6 force reads 0", A_FO, 32'h0);
    waitEdges(2);
    check("R7 masked source quiet", {31'b0, irqOut}, 32'h0);
    busWrite(A_EN, 32'h20);
    waitEdges(1);
    check("R8 level asserted", {31'b0, irqOut}, 32'h1);
    waitEdges(3);
    check("R8 level held", {31'b0, irqOut}, 32'h1);
    busWrite(A_ST, 32'h20);
    waitEdges(1);
    check("R8 level released by ack", {31'b0, irqOut}, 32'h0);

    busWrite(A_OP, 32'h1);
    check("R10 active-low idle", {31'b0, irqOut}, 32'h1);
    busWrite(A_FO, 32'h20);
    waitEdges(1);
    check("R10 active-low asserted", {31'b0, irqOut}, 32'h0);
    busWrite(A_ST, 32'h20);
    waitEdges(1);
    check("R10 active-low released", {31'b0, irqOut}, 32'h1);
    busWrite(A_OP, 32'h0);
    check("R10 back to active-high", {31'b0, irqOut}, 32'h0);

    busWrite(A_OM, 32'h1);
    busWrite(A_FO, 32'h20);
    waitEdges(1);
    check("R9 pulse high", {31'b0, irqOut}, 32'h1);
    waitEdges(1);
    check("R9 pulse one cycle", {31'b0, irqOut}, 32'h0);
    waitEdges(3);
    check("R9 no repeat while pending", {31'b0, irqOut}, 32'h0);
    busWrite(A_EN, 32'h60);
    busWrite(A_FO, 32'h40);
    waitEdges(1);
    check("R9 second event pulse", {31'b0, irqOut}, 32'h1);
    waitEdges(1);
    check("R9 second pulse ends", {31'b0, irqOut}, 32'h0);
    busWrite(A_ST, 32'hFFFF_FFFF);
    busWrite(A_OM, 32'h0);
    waitEdges(1);
    check("R8 idle after clear", {31'b0, irqOut}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule